// File: doc/BRIEF.md
# Presettable Up/Down Counter with Terminal-Count Flag

This block is a 4-bit synchronous counter that steps up or down on each rising clock edge while its active-low enable is held low. The direction is set by a select line: low counts up, high counts down. An active-low load copies a 4-bit data word into the count on the next edge, and load wins over counting. A parameter sets the modulus to 10 (decade) or 16 (binary). There is no clear input. A power-on reset starts the count at zero.

The flag output marks the terminal count for the current direction. Going up, the terminal count is the top state (9 or 15). Going down, it is zero. The active-low ripple output is a one-cycle clock-enable pulse. It goes low while the counter is enabled and at its terminal count. Counters are chained by tying one stage's ripple output to the next stage's enable. The moduli of chained stages multiply.

Top module: `updown_ctr`

## Requirements
- R1: While `rst_n` is low, the count is 0. Reset is asynchronous.
- R2: With `load_n` low, the count equals `din` after the next rising edge, whatever `cnt_en_n` and `dir_down` are.
- R3: With `load_n` high and `cnt_en_n` high, the count does not change.
- R4: With `load_n` high, `cnt_en_n` low and `dir_down` low, the count goes up by one per edge. From the top state (MODULUS-1) it wraps to 0.
- R5: With `load_n` high, `cnt_en_n` low and `dir_down` high, the count goes down by one per edge. From 0 it wraps to MODULUS-1.
- R6: `tc_flag` is 1 exactly when `dir_down` is 0 and the count is MODULUS-1, or when `dir_down` is 1 and the count is 0. It does not depend on the enable.
- R7: `ripple_n` is 0 exactly when `cnt_en_n` is 0 and `tc_flag` is 1. Otherwise it is 1.
- R8: With MODULUS=10, an enabled step from a loaded value of 10 to 15 goes to 0 when counting up and to 9 when counting down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| cnt_en_n | input | 1 | Count enable, active low |
| dir_down | input | 1 | Direction: 0 counts up, 1 counts down |
| load_n | input | 1 | Parallel load, active low |
| din | input | 4 | Data word for the load |
| count | output | 4 | Current count |
| tc_flag | output | 1 | Terminal-count flag for the current direction |
| ripple_n | output | 1 | Active-low cascade pulse: enabled and at terminal count |

## Verification
The clocked properties assume that the inputs are settled and free of X at every rising edge. The bench meets this by changing inputs only one nanosecond after an edge. The decade wrap properties also assume a legal count, so stepping from a value above 9 is covered by its own property. The bench reaches those values only through the load. It then steps once in each direction and compares a binary and a decade instance side by side.

// File: rtl/updown_ctr.sv
module updown_ctr #(
  parameter int MODULUS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cnt_en_n,
  input  logic       dir_down,
  input  logic       load_n,
  input  logic [3:0] din,
  output logic [3:0] count,
  output logic       tc_flag,
  output logic       ripple_n
);
  localparam logic [3:0] TOP = 4'(MODULUS - 1);

  logic [3:0] cnt_q, up_val, dn_val;
  logic       off_range;

  generate
    if (MODULUS == 16) begin : g_bin
      assign off_range = 1'b0;
    end else begin : g_dec
      assign off_range = cnt_q > TOP;
    end
  endgenerate

  assign up_val = (cnt_q == TOP || off_range) ? 4'd0 : cnt_q + 4'd1;
  assign dn_val = (cnt_q == 4'd0 || off_range) ? TOP : cnt_q - 4'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= 4'd0;
    else if (!load_n)   cnt_q <= din;
    else if (!cnt_en_n) cnt_q <= dir_down ? dn_val : up_val;
  end

  assign count    = cnt_q;
  assign tc_flag  = dir_down ? (cnt_q == 4'd0) : (cnt_q == TOP);
  assign ripple_n = ~(~cnt_en_n & tc_flag);

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |=> count == $past(din)); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && cnt_en_n) |=> $stable(count)); // R3
  AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !cnt_en_n && !dir_down && count < TOP) |=> count == 4'($past(count) + 4'd1)); // R4
  AST_UP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !cnt_en_n && !dir_down && count == TOP) |=> count == 4'd0); // R4
  AST_DN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !cnt_en_n && dir_down && count != 4'd0 && count <= TOP) |=> count == 4'($past(count) - 4'd1)); // R5
  AST_DN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !cnt_en_n && dir_down && count == 4'd0) |=> count == TOP); // R5
  AST_FLAG_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    tc_flag |-> (count == 4'd0 || count == TOP)); // R6
  AST_RIPPLE_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !ripple_n |-> (!cnt_en_n && tc_flag)); // R7
  AST_OFF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !cnt_en_n && count > TOP) |=> (count == 4'd0 || count == TOP)); // R8
endmodule

// File: tb/updown_ctr_tb.sv
module updown_ctr_tb;
  logic clk = 1'b0, rst_n = 1'b0, cnt_en_n = 1'b1, dir_down = 1'b0, load_n = 1'b1;
  logic [3:0] din = 4'd0;
  logic [3:0] cnt_b, cnt_d;
  logic tc_b, tc_d, rp_b, rp_d;
  int checks = 0, fails = 0;
  int exp_b = 0, exp_d = 0;

  always #2 clk = ~clk;

  updown_ctr #(.MODULUS(16)) u_dut (.clk(clk), .rst_n(rst_n), .cnt_en_n(cnt_en_n),
    .dir_down(dir_down), .load_n(load_n), .din(din), .count(cnt_b), .tc_flag(tc_b), .ripple_n(rp_b));
  updown_ctr #(.MODULUS(10)) u_dut_dec (.clk(clk), .rst_n(rst_n), .cnt_en_n(cnt_en_n),
    .dir_down(dir_down), .load_n(load_n), .din(din), .count(cnt_d), .tc_flag(tc_d), .ripple_n(rp_d));

  task automatic chk(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int nxt(int m, int cur);
    if (!load_n) return int'(din);
    if (cnt_en_n) return cur;
    if (!dir_down) return (cur >= m - 1) ? 0 : cur + 1;
    return (cur == 0 || cur > m - 1) ? m - 1 : cur - 1;
  endfunction

  function automatic int tcx(int m, int cur);
    return dir_down ? int'(cur == 0) : int'(cur == m - 1);
  endfunction

  task automatic step(string req);
    @(posedge clk);
    exp_b = nxt(16, exp_b);
    exp_d = nxt(10, exp_d);
    #1;
    chk(req, int'(cnt_b), exp_b);
    chk(req, int'(cnt_d), exp_d);
    chk("R6 flag", int'(tc_b), tcx(16, exp_b));
    chk("R6 flag", int'(tc_d), tcx(10, exp_d));
    chk("R7 ripple", int'(rp_b), int'(!(!cnt_en_n && tcx(16, exp_b) == 1)));
    chk("R7 ripple", int'(rp_d), int'(!(!cnt_en_n && tcx(10, exp_d) == 1)));
  endtask

  task automatic t_reset();
    #1;
    chk("R1 reset", int'(cnt_b), 0);
    chk("R1 reset", int'(cnt_d), 0);
    @(posedge clk); #1;
    chk("R1 reset held", int'(cnt_b), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_load();
    load_n = 1'b0; cnt_en_n = 1'b0; din = 4'd7; step("R2 load over enable");
    din = 4'd3; dir_down = 1'b1; step("R2 load down");
    load_n = 1'b1; cnt_en_n = 1'b1;
  endtask

  task automatic t_hold();
    for (int i = 0; i < 3; i++) step("R3 hold");
    dir_down = 1'b0; step("R3 hold dir change");
  endtask

  task automatic t_up();
    load_n = 1'b0; din = 4'd5; step("R2 preload");
    load_n = 1'b1; cnt_en_n = 1'b0; dir_down = 1'b0;
    for (int i = 0; i < 20; i++) step("R4 up/wrap");
    cnt_en_n = 1'b1;
  endtask

  task automatic t_down();
    load_n = 1'b0; din = 4'd2; step("R2 preload");
    load_n = 1'b1; cnt_en_n = 1'b0; dir_down = 1'b1;
    for (int i = 0; i < 20; i++) step("R5 down/wrap");
    cnt_en_n = 1'b1;
  endtask

  task automatic t_flags();
    load_n = 1'b0; din = 4'd9; step("R2 preload");
    load_n = 1'b1; cnt_en_n = 1'b1; dir_down = 1'b0; step("R6 flag idle");
    dir_down = 1'b1; step("R6 flag other dir");
    load_n = 1'b0; din = 4'd0; step("R2 preload");
    load_n = 1'b1; step("R6 flag zero down");
    cnt_en_n = 1'b0; #1;
    chk("R7 ripple low", int'(rp_b), 0);
    chk("R7 ripple low", int'(rp_d), 0);
    cnt_en_n = 1'b1; #1;
    chk("R7 ripple idle", int'(rp_b), 1);
  endtask

  task automatic t_off_range();
    for (int v = 10; v < 16; v++) begin
      load_n = 1'b0; din = 4'(v); step("R8 load");
      load_n = 1'b1; cnt_en_n = 1'b0; dir_down = 1'b0; step("R8 up recover");
      cnt_en_n = 1'b1; load_n = 1'b0; step("R8 reload");
      load_n = 1'b1; cnt_en_n = 1'b0; dir_down = 1'b1; step("R8 down recover");
      cnt_en_n = 1'b1;
    end
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_load();
    t_hold();
    t_up();
    t_down();
    t_flags();
    t_off_range();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule